// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns a 6-bit operand selector of a 16-bit-word processor into a full description of the access that operand stands for. It covers eight kinds of access in one 64-code space:

- a general register;
- memory through a register;
- memory through an extension word plus a register;
- the three stack forms (pop, peek, push);
- the stack pointer, program counter and overflow register as operands;
- memory through an extension word alone;
- an extension word used as an immediate;
- a short literal carried in the code itself.

Alongside the code, the caller supplies the eight register values, SP, PC and the word fetched at PC. The block reports:

- the operand kind;
- the effective address;
- the literal value;
- whether the extension word was consumed;
- the resulting SP and PC.

A request flows in over a valid/ready handshake and the result flows out through one register stage with its own valid/ready pair. A result is offered on `out_valid` and held, unchanged, until `out_ready` is seen high at a clock edge. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a stalled consumer stalls the producer with no loss and no duplication.

Two control inputs shape the result. A destination flag marks an operand that is about to be written; when that operand is a literal, the block raises a write-ignore flag. A skip flag is used while stepping over an instruction that will not execute: PC still moves past any extension word, but no access is described and SP is left alone.

Top module: `opdec_unit`

## Requirements
- R1: Codes 0x00 to 0x07 give kind 0 (register) with out_addr holding the register index (code & 7, A=0 through J=7) and out_lit zero.
- R2: Codes 0x08 to 0x0F give kind 1 (memory) with out_addr equal to the value of register (code & 7); no extension word is used and PC is unchanged.
- R3: Codes 0x10 to 0x17 give kind 1 with out_addr = extension word + register (code & 7); out_ext_used is 1 and out_new_pc = PC + 1.
- R4: Code 0x18 gives kind 1 at address SP with new SP = SP + 1. Code 0x19 gives kind 1 at SP with SP unchanged. Code 0x1A gives kind 1 at SP - 1 with new SP = SP - 1.
- R5: Codes 0x1B, 0x1C and 0x1D give kinds 2 (SP), 3 (PC) and 4 (overflow register) respectively, with out_addr and out_lit zero and SP and PC unchanged.
- R6: Code 0x1E gives kind 1 at the extension word. Code 0x1F gives kind 5 (literal) with out_lit equal to the extension word. Both set out_ext_used and advance PC by one.
- R7: Codes 0x20 to 0x3F give kind 5 with out_lit = code - 0x20 (0 to 31) and no extension word.
- R8: out_wr_ignore is 1 exactly when the destination flag is set and the resulting kind is 5; it is 0 for every other kind.
- R9: With the skip flag set, the kind is 6 (none), out_addr, out_lit and out_wr_ignore are zero, and SP is unchanged; PC still advances by one for codes 0x10 to 0x17, 0x1E and 0x1F.
- R10: All sums and differences on addresses, SP and PC wrap modulo 2^16.
- R11: A request accepted at a clock edge appears on the outputs after that edge with out_valid high; while out_valid is high and out_ready low, in_ready is low and every output stays stable.
- R12: After reset, out_valid and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_code | input | 6 | Operand selector |
| in_skip | input | 1 | Instruction is being stepped over |
| in_dest | input | 1 | Operand is a write destination |
| in_regs | input | 128 | Register file, register i at bits 16*i+15 down to 16*i |
| in_sp | input | 16 | Current stack pointer |
| in_pc | input | 16 | PC, already pointing at a possible extension word |
| in_ext | input | 16 | Word fetched at in_pc |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_kind | output | 3 | 0 register, 1 memory, 2 SP, 3 PC, 4 overflow, 5 literal, 6 none |
| out_addr | output | 16 | Memory address, or register index for kind 0 |
| out_lit | output | 16 | Literal value for kind 5 |
| out_ext_used | output | 1 | Extension word consumed |
| out_wr_ignore | output | 1 | Writes to this destination are discarded |
| out_new_sp | output | 16 | SP after the access |
| out_new_pc | output | 16 | PC after the operand |

## Verification
Two things can coincide at the output stage: the consumer can release a held result, and a fresh request can be accepted, on the same clock edge. The bench provokes this by holding out_ready low while one result sits in the stage, keeping a second request valid throughout the stall, and then raising out_ready. It checks three things: in_ready stayed low, the first result did not move during the stall, and the second result appears exactly one edge after the release. A second case of coincidence, skip mode on an indexed or extension-word code, is judged by checking that PC advances while the kind is none and SP is untouched.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int CODE_W = 6;
  localparam int SLIT_W = 5;

  typedef enum logic [2:0] {
    K_REG  = 3'd0,
    K_MEM  = 3'd1,
    K_SP   = 3'd2,
    K_PC   = 3'd3,
    K_OVF  = 3'd4,
    K_LIT  = 3'd5,
    K_NONE = 3'd6
  } opk_e;

  typedef enum logic [1:0] {SP_HOLD, SP_INC, SP_DEC} spop_e;

  typedef enum logic [2:0] {
    A_ZERO, A_REGIDX, A_REG, A_EXT_REG, A_SP, A_SP_DEC, A_EXT
  } asrc_e;

  typedef enum logic [1:0] {L_ZERO, L_SHORT, L_EXT} lsrc_e;
endpackage

// File: rtl/opdec_classify.sv
module opdec_classify
  import opdec_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              skip,
  input  logic              dest,
  output opk_e              kind,
  output spop_e             spop,
  output asrc_e             asrc,
  output lsrc_e             lsrc,
  output logic              ext_used,
  output logic              wr_ignore
);
  always_comb begin
    kind     = K_NONE;
    spop     = SP_HOLD;
    asrc     = A_ZERO;
    lsrc     = L_ZERO;
    ext_used = 1'b0;
    if (code[5]) begin
      kind = K_LIT;
      lsrc = L_SHORT;
    end else begin
      case (code[4:3])
        2'd0: begin kind = K_REG; asrc = A_REGIDX; end
        2'd1: begin kind = K_MEM; asrc = A_REG; end
        2'd2: begin kind = K_MEM; asrc = A_EXT_REG; ext_used = 1'b1; end
        default: begin
          case (code[2:0])
            3'd0: begin kind = K_MEM; asrc = A_SP; spop = SP_INC; end
            3'd1: begin kind = K_MEM; asrc = A_SP; end
            3'd2: begin kind = K_MEM; asrc = A_SP_DEC; spop = SP_DEC; end
            3'd3: kind = K_SP;
            3'd4: kind = K_PC;
            3'd5: kind = K_OVF;
            3'd6: begin kind = K_MEM; asrc = A_EXT; ext_used = 1'b1; end
            default: begin kind = K_LIT; lsrc = L_EXT; ext_used = 1'b1; end
          endcase
        end
      endcase
    end
    // stepping over: only the PC advance survives
    if (skip) begin
      kind = K_NONE;
      spop = SP_HOLD;
      asrc = A_ZERO;
      lsrc = L_ZERO;
    end
    wr_ignore = dest && (kind == K_LIT);
  end
endmodule

// File: rtl/opdec_addr.sv
module opdec_addr
  import opdec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NREG   = 8,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic [RIDX_W-1:0]      ridx,
  input  logic [SLIT_W-1:0]      slit,
  input  logic [NREG*WORD_W-1:0] regs,
  input  logic [WORD_W-1:0]      sp,
  input  logic [WORD_W-1:0]      pc,
  input  logic [WORD_W-1:0]      ext,
  input  spop_e                  spop,
  input  asrc_e                  asrc,
  input  lsrc_e                  lsrc,
  input  logic                   ext_used,
  output logic [WORD_W-1:0]      addr,
  output logic [WORD_W-1:0]      lit,
  output logic [WORD_W-1:0]      new_sp,
  output logic [WORD_W-1:0]      new_pc
);
  logic [WORD_W-1:0] reg_arr [NREG];
  logic [WORD_W-1:0] reg_val;
  logic [WORD_W-1:0] sp_dec;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign reg_arr[g] = regs[g*WORD_W +: WORD_W];
  end

  assign reg_val = reg_arr[ridx];
  assign sp_dec  = sp - WORD_W'(1);

  always_comb begin
    case (asrc)
      A_REGIDX:  addr = WORD_W'(ridx);
      A_REG:     addr = reg_val;
      A_EXT_REG: addr = ext + reg_val;
      A_SP:      addr = sp;
      A_SP_DEC:  addr = sp_dec;
      A_EXT:     addr = ext;
      default:   addr = '0;
    endcase
    case (lsrc)
      L_SHORT: lit = WORD_W'(slit);
      L_EXT:   lit = ext;
      default: lit = '0;
    endcase
    case (spop)
      SP_INC:  new_sp = sp + WORD_W'(1);
      SP_DEC:  new_sp = sp_dec;
      default: new_sp = sp;
    endcase
    new_pc = pc + WORD_W'(ext_used);
  end
endmodule

// File: rtl/opdec_unit.sv
module opdec_unit
  import opdec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NREG   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [5:0]             in_code,
  input  logic                   in_skip,
  input  logic                   in_dest,
  input  logic [NREG*WORD_W-1:0] in_regs,
  input  logic [WORD_W-1:0]      in_sp,
  input  logic [WORD_W-1:0]      in_pc,
  input  logic [WORD_W-1:0]      in_ext,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [2:0]             out_kind,
  output logic [WORD_W-1:0]      out_addr,
  output logic [WORD_W-1:0]      out_lit,
  output logic                   out_ext_used,
  output logic                   out_wr_ignore,
  output logic [WORD_W-1:0]      out_new_sp,
  output logic [WORD_W-1:0]      out_new_pc
);
  localparam int RIDX_W = $clog2(NREG);

  opk_e              c_kind;
  spop_e             c_spop;
  asrc_e             c_asrc;
  lsrc_e             c_lsrc;
  logic              c_ext, c_wri;
  logic [WORD_W-1:0] c_addr, c_lit, c_sp, c_pc;
  logic              fire;

  opdec_classify u_cls (
    .code(in_code), .skip(in_skip), .dest(in_dest),
    .kind(c_kind), .spop(c_spop), .asrc(c_asrc), .lsrc(c_lsrc),
    .ext_used(c_ext), .wr_ignore(c_wri)
  );

  opdec_addr #(.WORD_W(WORD_W), .NREG(NREG)) u_addr (
    .ridx(in_code[RIDX_W-1:0]), .slit(in_code[SLIT_W-1:0]),
    .regs(in_regs), .sp(in_sp), .pc(in_pc), .ext(in_ext),
    .spop(c_spop), .asrc(c_asrc), .lsrc(c_lsrc), .ext_used(c_ext),
    .addr(c_addr), .lit(c_lit), .new_sp(c_sp), .new_pc(c_pc)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_kind      <= '0;
      out_addr      <= '0;
      out_lit       <= '0;
      out_ext_used  <= 1'b0;
      out_wr_ignore <= 1'b0;
      out_new_sp    <= '0;
      out_new_pc    <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (fire) begin
        out_kind      <= c_kind;
        out_addr      <= c_addr;
        out_lit       <= c_lit;
        out_ext_used  <= c_ext;
        out_wr_ignore <= c_wri;
        out_new_sp    <= c_sp;
        out_new_pc    <= c_pc;
      end
    end
  end

  // R11: a stalled result does not move
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_addr)
      && $stable(out_lit) && $stable(out_new_sp) && $stable(out_new_pc)));

  // R9: skip describes no access and leaves SP alone
  a_r9_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_skip) |=> (out_kind == 3'(K_NONE) && out_new_sp == $past(in_sp)
      && !out_wr_ignore));

  // R7: short literal equals the low five code bits
  a_r7_short_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_code[5] && !in_skip) |=> (out_kind == 3'(K_LIT)
      && out_lit == WORD_W'($past(in_code[4:0])) && !out_ext_used));

  // R8: write-ignore only ever accompanies a literal
  a_r8_ignore_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_ignore) |-> (out_kind == 3'(K_LIT)));

  // R3 / R6: extension codes advance PC by one
  a_r6_ext_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_code == 6'h1E || in_code == 6'h1F || in_code[5:3] == 3'b010))
      |=> (out_ext_used && out_new_pc == $past(in_pc) + WORD_W'(1)));

  // R4: peek reads SP and keeps it
  a_r4_peek: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_code == 6'h19 && !in_skip)
      |=> (out_addr == $past(in_sp) && out_new_sp == $past(in_sp)));
endmodule

// File: tb/test_opdec_unit.sv
module test_opdec_unit;
  localparam int W = 16;
  localparam int NR = 8;
  localparam int NROW = 20;
  localparam int RW = 77;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [5:0] in_code = '0;
  logic in_skip = 1'b0, in_dest = 1'b0;
  logic [NR*W-1:0] in_regs = '0;
  logic [W-1:0] in_sp = 16'h8000, in_pc = 16'h0040, in_ext = 16'h0200;
  logic out_valid, out_ready = 1'b1;
  logic [2:0] out_kind;
  logic [W-1:0] out_addr, out_lit, out_new_sp, out_new_pc;
  logic out_ext_used, out_wr_ignore;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opdec_unit #(.WORD_W(W), .NREG(NR)) i_opdec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_skip(in_skip), .in_dest(in_dest), .in_regs(in_regs),
    .in_sp(in_sp), .in_pc(in_pc), .in_ext(in_ext), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_addr(out_addr), .out_lit(out_lit),
    .out_ext_used(out_ext_used), .out_wr_ignore(out_wr_ignore),
    .out_new_sp(out_new_sp), .out_new_pc(out_new_pc)
  );

  // row: code, skip, dest | kind, addr, lit, ext, wri, new_sp, new_pc
  // registers A..J = 0x1000..0x1007, SP 0x8000, PC 0x0040, ext 0x0200
  localparam logic [RW-1:0] TBL [NROW] = '{
    {6'h05,1'b0,1'b0, 3'd0,16'h0005,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R1
    {6'h02,1'b0,1'b1, 3'd0,16'h0002,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R1 dest reg
    {6'h0A,1'b0,1'b0, 3'd1,16'h1002,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R2
    {6'h0F,1'b0,1'b0, 3'd1,16'h1007,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R2
    {6'h10,1'b0,1'b0, 3'd1,16'h1200,16'h0000,1'b1,1'b0,16'h8000,16'h0041}, // R3
    {6'h13,1'b0,1'b0, 3'd1,16'h1203,16'h0000,1'b1,1'b0,16'h8000,16'h0041}, // R3
    {6'h18,1'b0,1'b0, 3'd1,16'h8000,16'h0000,1'b0,1'b0,16'h8001,16'h0040}, // R4 pop
    {6'h19,1'b0,1'b0, 3'd1,16'h8000,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R4 peek
    {6'h1A,1'b0,1'b0, 3'd1,16'h7FFF,16'h0000,1'b0,1'b0,16'h7FFF,16'h0040}, // R4 push
    {6'h1B,1'b0,1'b0, 3'd2,16'h0000,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R5
    {6'h1C,1'b0,1'b0, 3'd3,16'h0000,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R5
    {6'h1D,1'b0,1'b0, 3'd4,16'h0000,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R5
    {6'h1E,1'b0,1'b0, 3'd1,16'h0200,16'h0000,1'b1,1'b0,16'h8000,16'h0041}, // R6
    {6'h1F,1'b0,1'b0, 3'd5,16'h0000,16'h0200,1'b1,1'b0,16'h8000,16'h0041}, // R6
    {6'h1F,1'b0,1'b1, 3'd5,16'h0000,16'h0200,1'b1,1'b1,16'h8000,16'h0041}, // R8
    {6'h20,1'b0,1'b1, 3'd5,16'h0000,16'h0000,1'b0,1'b1,16'h8000,16'h0040}, // R7 R8
    {6'h3F,1'b0,1'b0, 3'd5,16'h0000,16'h001F,1'b0,1'b0,16'h8000,16'h0040}, // R7
    {6'h1A,1'b1,1'b0, 3'd6,16'h0000,16'h0000,1'b0,1'b0,16'h8000,16'h0040}, // R9
    {6'h17,1'b1,1'b0, 3'd6,16'h0000,16'h0000,1'b1,1'b0,16'h8000,16'h0041}, // R9
    {6'h2A,1'b1,1'b1, 3'd6,16'h0000,16'h0000,1'b0,1'b0,16'h8000,16'h0040}  // R9
  };

  function automatic string req_of(input logic [5:0] c, input logic s, input logic d);
    if (s) return "R9";
    if (d && (c[5] || c == 6'h1F)) return "R8";
    if (c[5]) return "R7";
    if (c[4:3] == 2'd0) return "R1";
    if (c[4:3] == 2'd1) return "R2";
    if (c[4:3] == 2'd2) return "R3";
    if (c[2:0] <= 3'd2) return "R4";
    if (c[2:0] <= 3'd5) return "R5";
    return "R6";
  endfunction

  function automatic logic [68:0] actual();
    return {out_kind, out_addr, out_lit, out_ext_used, out_wr_ignore, out_new_sp, out_new_pc};
  endfunction

  task automatic check(input bit ok, input string req, input logic [68:0] act, input logic [68:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] c, input logic s, input logic d);
    @(negedge clk);
    in_code = c; in_skip = s; in_dest = d; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [68:0] exp);
    check(out_valid && actual() == exp, req, actual(), exp);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) in_regs[i*W +: W] = 16'h1000 + W'(i);
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!out_valid && actual() == '0, "R12", actual(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R12", {68'd0, in_ready}, 69'd1);

    for (int i = 0; i < NROW; i++) begin
      logic [RW-1:0] row;
      row = TBL[i];
      send(row[76:71], row[70], row[69]);
      expect_out(req_of(row[76:71], row[70], row[69]), row[68:0]);
    end

    // R10: push wraps below zero
    in_sp = 16'h0000;
    send(6'h1A, 1'b0, 1'b0);
    expect_out("R10", {3'd1,16'hFFFF,16'h0000,1'b0,1'b0,16'hFFFF,16'h0040});
    // R10: pop wraps above 0xFFFF
    in_sp = 16'hFFFF;
    send(6'h18, 1'b0, 1'b0);
    expect_out("R10", {3'd1,16'hFFFF,16'h0000,1'b0,1'b0,16'h0000,16'h0040});
    // R10: indexed sum wraps, PC wraps
    in_sp = 16'h8000; in_ext = 16'hFFFF; in_pc = 16'hFFFF;
    send(6'h17, 1'b0, 1'b0);
    expect_out("R10", {3'd1,16'h1006,16'h0000,1'b1,1'b0,16'h8000,16'h0000});
    in_ext = 16'h0200; in_pc = 16'h0040;

    // R11: stall with a second request waiting
    @(negedge clk);
    out_ready = 1'b0;
    send(6'h0B, 1'b0, 1'b0);
    check(!in_ready, "R11", {68'd0, in_ready}, 69'd0);
    in_code = 6'h3C; in_skip = 1'b0; in_dest = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_out("R11", {3'd1,16'h1003,16'h0000,1'b0,1'b0,16'h8000,16'h0040});
    check(!in_ready, "R11", {68'd0, in_ready}, 69'd0);
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    expect_out("R11", {3'd5,16'h0000,16'h001C,1'b0,1'b0,16'h8000,16'h0040});
    @(negedge clk);
    check(!out_valid, "R11", {68'd0, out_valid}, 69'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule